// File: doc/BRIEF.md
# Failsafe Two-Stage Watchdog

This block supervises software liveness through an active-low clear input. Once the supply supervisor reports that the power-up sequence is complete, a timer counts a fixed timeout period made from a clock prescaler and a tick counter. Each qualified clear restarts the count. If the period runs out with no clear, the active-low warning output starts to toggle as a square wave, beginning with a low half. If the first low half also ends with no clear, the block raises a reset request. The request stays latched until a clear arrives or the supervisor starts a new power-up sequence.

The clear input is synchronised and filtered. A low level must be held for a minimum number of clock cycles before it counts as a clear. A held level counts only once. While the supervisor reports that power-up is incomplete, or that the input voltage has dropped below the reset threshold, the watchdog is idle and ignores clears. The combined active-low reset output asserts for either the supervisor condition or the watchdog request.

Top module: `failsafe_wdog`

## Requirements
- R1: Under rst_ni low and afterwards while pwr_ok_i is low, warn_no is 1, wd_req_o is 0 and res_no is 0.
- R2: A clear is accepted only when clr_ni has been low for at least CLR_MIN_CYC consecutive clock cycles. A shorter low pulse does not restart the timeout.
- R3: clr_ni held low counts as exactly one clear. No further clear is accepted until clr_ni has returned high. With the input held at a constant level, warn_no keeps toggling.
- R4: An accepted clear sets warn_no to 1 and restarts the count from zero. Clears arriving more often than one timeout period (TICK_DIV*TIMEOUT_TICKS cycles) keep warn_no at 1 and wd_req_o at 0.
- R5: With no clear for one timeout period, warn_no goes to 0. It then inverts after every further timeout period, giving a square wave with a period of two timeouts.
- R6: wd_req_o rises at the end of the first low half of warn_no with no clear. It stays at 1 while warn_no keeps toggling.
- R7: An accepted clear returns warn_no to 1 and wd_req_o to 0 from any stage.
- R8: While pwr_ok_i is 0 or vdrop_i is 1, warn_no is 1, wd_req_o is 0 and clears have no effect. When the block is enabled again, the timeout counts from zero.
- R9: res_no is 1 only when pwr_ok_i is 1, vdrop_i is 0 and wd_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supervisor: power-up sequence complete |
| vdrop_i | input | 1 | Supervisor: input voltage below reset threshold |
| clr_ni | input | 1 | Timer clear from software, active low, asynchronous |
| warn_no | output | 1 | Timeout warning, active low |
| wd_req_o | output | 1 | Watchdog reset request, active high |
| res_no | output | 1 | Combined system reset, active low |

## Verification
The assertions assume that pwr_ok_i and vdrop_i are synchronous to clk_i and change only between edges. They also assume that a clear event and a timeout tick are never judged against a disabled cycle. The bench drives every input on the falling clock edge, so the supervisor inputs never change at an active edge. The bench times each clear pulse so that its qualified event falls at a known cycle relative to the timeout windows. All samples are taken at least several cycles away from any transition of warn_no or wd_req_o.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_WARN  = 2'd1,
    ST_FAIL  = 2'd2
  } wd_stage_e;
endpackage

// File: rtl/wdog_clr_qual.sv
module wdog_clr_qual #(
  parameter int CLR_MIN_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_ni,
  output logic clr_evt_o
);
  localparam int QW = $clog2(CLR_MIN_CYC + 1);
  localparam logic [QW-1:0] LASTQ = QW'(CLR_MIN_CYC - 1);

  logic [1:0]    sync_q;
  logic [QW-1:0] low_cnt_q;
  logic          used_q;
  logic          evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 2'b11;
      low_cnt_q <= '0;
      used_q    <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], clr_ni};
      evt_q  <= 1'b0;
      if (!en_i || sync_q[1]) begin
        low_cnt_q <= '0;
        used_q    <= 1'b0;
      end else if (!used_q) begin
        // one event per low level
        if (low_cnt_q == LASTQ) begin
          evt_q  <= 1'b1;
          used_q <= 1'b1;
        end else begin
          low_cnt_q <= low_cnt_q + 1'b1;
        end
      end
    end
  end

  assign clr_evt_o = evt_q;
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int TICK_DIV = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LASTC = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && !restart_i && (cnt_q == LASTC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_evt_i,
  input  logic tick_i,
  output logic warn_no,
  output logic req_o
);
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [TW-1:0] LASTT = TW'(TIMEOUT_TICKS - 1);

  wd_stage_e     stage_q;
  logic [TW-1:0] tcnt_q;
  logic          warn_q;
  logic          req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_ARMED;
      tcnt_q  <= '0;
      warn_q  <= 1'b1;
      req_q   <= 1'b0;
    end else if (!en_i || clr_evt_i) begin
      stage_q <= ST_ARMED;
      tcnt_q  <= '0;
      warn_q  <= 1'b1;
      req_q   <= 1'b0;
    end else if (tick_i) begin
      if (tcnt_q == LASTT) begin
        tcnt_q <= '0;
        warn_q <= !warn_q;
        case (stage_q)
          ST_ARMED: stage_q <= ST_WARN;
          ST_WARN: begin
            stage_q <= ST_FAIL;
            req_q   <= 1'b1;
          end
          default: stage_q <= ST_FAIL;
        endcase
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign warn_no = warn_q;
  assign req_o   = req_q;
endmodule

// File: rtl/failsafe_wdog.sv
module failsafe_wdog #(
  parameter int TICK_DIV      = 2000,
  parameter int TIMEOUT_TICKS = 1000,
  parameter int CLR_MIN_CYC   = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic vdrop_i,
  input  logic clr_ni,
  output logic warn_no,
  output logic wd_req_o,
  output logic res_no
);
  logic wd_en;
  logic clr_evt;
  logic tick;

  assign wd_en = pwr_ok_i && !vdrop_i;

  wdog_clr_qual #(.CLR_MIN_CYC(CLR_MIN_CYC)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wd_en),
    .clr_ni   (clr_ni),
    .clr_evt_o(clr_evt)
  );

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (wd_en),
    .restart_i(clr_evt),
    .tick_o   (tick)
  );

  wdog_core #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wd_en),
    .clr_evt_i(clr_evt),
    .tick_i   (tick),
    .warn_no  (warn_no),
    .req_o    (wd_req_o)
  );

  assign res_no = wd_en && !wd_req_o;
endmodule

// File: rtl/failsafe_wdog_chk.sv
module failsafe_wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic clr_evt_i,
  input logic warn_ni,
  input logic req_i,
  input logic res_ni
);
  p_idle_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (warn_ni && !req_i));

  p_req_after_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |-> $past(!warn_ni));

  p_req_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && en_i && !clr_evt_i) |=> req_i);

  p_clear_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_evt_i) |=> (warn_ni && !req_i));

  p_res_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !res_ni);
endmodule

bind failsafe_wdog failsafe_wdog_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (wd_en),
  .clr_evt_i(clr_evt),
  .warn_ni  (warn_no),
  .req_i    (wd_req_o),
  .res_ni   (res_no)
);

// File: tb/failsafe_wdog_tb_top.sv
`timescale 1ns/1ps
module failsafe_wdog_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic vdrop = 1'b0;
  logic clr_n = 1'b1;
  logic warn_n, req, res_n;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  failsafe_wdog #(.TICK_DIV(4), .TIMEOUT_TICKS(5), .CLR_MIN_CYC(3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .vdrop_i(vdrop),
    .clr_ni(clr_n), .warn_no(warn_n), .wd_req_o(req), .res_no(res_n)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drives low for len cycles; qualified restart lands 6 edges after start
  task automatic pulse_clr(input int len);
    clr_n = 1'b0;
    wait_cyc(len);
    clr_n = 1'b1;
  endtask

  task automatic t_reset_r1();
    chk(warn_n == 1'b1, "R1 warn", warn_n, 1);
    chk(req == 1'b0, "R1 req", req, 0);
    chk(res_n == 1'b0, "R1 res", res_n, 0);
    rst_n = 1'b1;
    wait_cyc(2);
    pulse_clr(5);
    wait_cyc(30);
    chk(warn_n == 1'b1 && req == 1'b0, "R1 idle before pwr_ok", warn_n, 1);
    // enable: first warn low after 20 edges
    pwr_ok = 1'b1;
    wait_cyc(10);
    chk(warn_n == 1'b1, "R8 count from enable high", warn_n, 1);
    wait_cyc(20);
    chk(warn_n == 1'b0, "R8 count from enable low", warn_n, 0);
  endtask

  task automatic t_timeout_r5_r6();
    pulse_clr(5);
    wait_cyc(11);
    chk(warn_n == 1'b1, "R4 warn high after clear", warn_n, 1);
    wait_cyc(20);
    chk(warn_n == 1'b0, "R5 first low half", warn_n, 0);
    chk(req == 1'b0, "R6 no req in low half", req, 0);
    wait_cyc(20);
    chk(req == 1'b1, "R6 req after low half", req, 1);
    chk(warn_n == 1'b1, "R5 second toggle", warn_n, 1);
    chk(res_n == 1'b0, "R9 res with req", res_n, 0);
    wait_cyc(20);
    chk(warn_n == 1'b0 && req == 1'b1, "R6 req latched, warn toggles", {warn_n, req}, 1);
    wait_cyc(20);
    chk(warn_n == 1'b1 && req == 1'b1, "R5 square wave continues", {warn_n, req}, 3);
  endtask

  task automatic t_release_r7();
    pulse_clr(5);
    wait_cyc(5);
    chk(req == 1'b0, "R7 req released", req, 0);
    chk(warn_n == 1'b1, "R7 warn released", warn_n, 1);
    chk(res_n == 1'b1, "R9 res high when enabled no req", res_n, 1);
  endtask

  task automatic t_glitch_r2();
    pulse_clr(5);
    wait_cyc(9);
    pulse_clr(2);
    wait_cyc(14);
    chk(warn_n == 1'b0, "R2 short pulse ignored", warn_n, 0);
  endtask

  task automatic t_keepalive_r4();
    int errs = 0;
    for (int i = 0; i < 8; i++) begin
      pulse_clr(5);
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (warn_n !== 1'b1 || req !== 1'b0) errs++;
      end
    end
    chk(errs == 0, "R4 keepalive holds warn high", errs, 0);
  endtask

  task automatic t_held_r3();
    clr_n = 1'b0;
    wait_cyc(16);
    chk(warn_n == 1'b1, "R3 held low cleared once", warn_n, 1);
    wait_cyc(20);
    chk(warn_n == 1'b0, "R3 held low no re-clear", warn_n, 0);
    wait_cyc(20);
    chk(req == 1'b1, "R3 held low reaches req", req, 1);
    wait_cyc(20);
    chk(warn_n == 1'b0, "R3 square wave with constant input", warn_n, 0);
    clr_n = 1'b1;
    wait_cyc(3);
  endtask

  task automatic t_drop_r8();
    int errs = 0;
    chk(req == 1'b1, "R8 precondition req", req, 1);
    vdrop = 1'b1;
    wait_cyc(2);
    chk(warn_n == 1'b1 && req == 1'b0, "R8 drop idles outputs", {warn_n, req}, 2);
    chk(res_n == 1'b0, "R9 res low on drop", res_n, 0);
    pulse_clr(5);
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      if (warn_n !== 1'b1 || req !== 1'b0) errs++;
    end
    chk(errs == 0, "R8 clears ignored while dropped", errs, 0);
    vdrop = 1'b0;
    wait_cyc(10);
    chk(warn_n == 1'b1 && res_n == 1'b1, "R8 re-enable fresh count high", {warn_n, res_n}, 3);
    wait_cyc(20);
    chk(warn_n == 1'b0, "R8 re-enable fresh count low", warn_n, 0);
    pwr_ok = 1'b0;
    wait_cyc(1);
    chk(res_n == 1'b0, "R9 res low without pwr_ok", res_n, 0);
  endtask

  initial begin
    wait_cyc(3);
    t_reset_r1();
    t_timeout_r5_r6();
    t_release_r7();
    t_glitch_r2();
    t_keepalive_r4();
    t_held_r3();
    t_drop_r8();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule